// File: doc/BRIEF.md
# Selectable-Polarity Parity Codec

This block protects characters moving between units of a chip with a single redundant bit. For every message word it presents, it produces the parity bit that a sender appends. At the same moment it checks a received word, which is the message plus the parity bit that came with it, and reports whether the number of ones breaks the agreed rule. One run-time control pin picks the rule for both halves: even parity, or odd parity. The checker reaches odd parity by inverting the result of its XOR tree, so it does not need a second tree.

The message width is a parameter. The default of seven message bits fills one byte with a parity bit and covers a 128-character set. A width of eight serves a full byte with a ninth parity bit. Both the generator and the checker reduce their inputs through a balanced XOR tree whose depth is the ceiling of log2 of the number of inputs.

Words enter and leave through a valid/ready stream. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. With `REGISTERED = 1` the results sit in a one-entry output register. They appear with `out_valid` one cycle after the word is accepted. While `out_valid` is high and `out_ready` is low, the outputs hold and `in_ready` is low, so back-pressure passes straight upstream. If the register is empty, or is being emptied in the same cycle, a new word is accepted. With `REGISTERED = 0` the block is pure logic: valid and ready pass through unchanged and the results follow the inputs within the same cycle.

Top module: `parity_codec`

## Requirements
- R1: With `odd_sel` = 0 (even rule), `out_par` equals the XOR of all `MSG_W` message bits of the word.
- R2: With `odd_sel` = 1 (odd rule), `out_par` is the complement of the XOR of the message bits.
- R3: `out_err` is 1 when the ones in the message bits plus `in_par` break the selected rule (an odd total under the even rule, an even total under the odd rule), and 0 when the word obeys the rule.
- R4: Flipping any single bit of a correctly coded word, either one message bit or the parity bit, drives `out_err` to 1 under either rule.
- R5: Flipping any two distinct bits of a correctly coded word leaves `out_err` at 0.
- R6: With `MSG_W` = 8, a nine-bit word (eight message bits plus one parity bit) is generated and checked under the same rules.
- R7: With `REGISTERED` = 1, a word accepted on one rising edge has its `out_par` and `out_err` presented with `out_valid` = 1 after that edge. The results stay there until the next accepted word.
- R8: With `REGISTERED` = 1, while `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and `out_valid`, `out_par` and `out_err` hold their values over the next edge.
- R9: While `rst_n` is low in registered mode, `out_valid` is 0 and `in_ready` is 1.
- R10: With `REGISTERED` = 0, `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and the results follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| odd_sel | input | 1 | Parity rule: 0 selects even, 1 selects odd |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | MSG_W | Message bits |
| in_par | input | 1 | Received parity bit that goes with `in_data` |
| out_valid | output | 1 | Results are valid |
| out_ready | input | 1 | Consumer takes the results |
| out_par | output | 1 | Generated parity bit for the message |
| out_err | output | 1 | 1 when the received word breaks the rule |

## Verification
The bench builds two copies of the block. The first uses the default seven-bit message with the output register. It streams every one of the 128 messages under both rules, with random received parity bits, and it includes a stall that exercises the hold and back-pressure behaviour. The second uses an eight-bit message without the register, which puts a nine-bit word and the same-cycle pass-through within reach. On that copy every one of the 256 messages under both rules is coded correctly, then struck with each possible single-bit flip and with a random pair of flips. Random words from a fixed seed are added on top of this sweep.

// File: rtl/parity_codec_pkg.sv
package parity_codec_pkg;

  typedef enum logic {
    RULE_EVEN = 1'b0,
    RULE_ODD  = 1'b1
  } parity_rule_e;

  // Leaf count of a balanced binary reduction over w inputs
  function automatic int tree_leaves(input int w);
    return (w <= 1) ? 1 : (1 << $clog2(w));
  endfunction

  function automatic int tree_depth(input int w);
    return (w <= 1) ? 0 : $clog2(w);
  endfunction

endpackage

// File: rtl/parity_xor_tree.sv
module parity_xor_tree
  import parity_codec_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] bits,
  output logic         folded
);

  localparam int LEAVES = tree_leaves(W);
  localparam int DEPTH  = tree_depth(W);

  for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
    localparam int NW = LEAVES >> l;
    logic [NW-1:0] v;
    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < NW; k++) begin : g_bit
        if (k < W) begin : g_real
          assign v[k] = bits[k];
        end else begin : g_pad
          assign v[k] = 1'b0;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < NW; j++) begin : g_pair
        assign v[j] = g_lvl[l-1].v[2*j] ^ g_lvl[l-1].v[2*j+1];
      end
    end
  end

  assign folded = g_lvl[DEPTH].v[0];

endmodule

// File: rtl/parity_encoder.sv
module parity_encoder
  import parity_codec_pkg::*;
#(
  parameter int MSG_W = 7
) (
  input  logic [MSG_W-1:0] msg,
  input  parity_rule_e     rule,
  output logic             par
);

  logic fold;

  parity_xor_tree #(.W(MSG_W)) u_tree (
    .bits   (msg),
    .folded (fold)
  );

  // Odd rule flips the generated bit
  assign par = fold ^ (rule == RULE_ODD);

endmodule

// File: rtl/parity_checker.sv
module parity_checker
  import parity_codec_pkg::*;
#(
  parameter int MSG_W = 7
) (
  input  logic [MSG_W-1:0] msg,
  input  logic             par,
  input  parity_rule_e     rule,
  output logic             err
);

  localparam int WORD_W = MSG_W + 1;

  logic fold;

  parity_xor_tree #(.W(WORD_W)) u_tree (
    .bits   ({par, msg}),
    .folded (fold)
  );

  // Even rule: odd count is an error. Odd rule: invert the tree output.
  assign err = fold ^ (rule == RULE_ODD);

endmodule

// File: rtl/parity_codec.sv
module parity_codec
  import parity_codec_pkg::*;
#(
  parameter int MSG_W      = 7,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             odd_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [MSG_W-1:0] in_data,
  input  logic             in_par,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_par,
  output logic             out_err
);

  parity_rule_e rule;
  logic         gen_par;
  logic         chk_err;

  assign rule = odd_sel ? RULE_ODD : RULE_EVEN;

  parity_encoder #(.MSG_W(MSG_W)) u_enc (
    .msg  (in_data),
    .rule (rule),
    .par  (gen_par)
  );

  parity_checker #(.MSG_W(MSG_W)) u_chk (
    .msg  (in_data),
    .par  (in_par),
    .rule (rule),
    .err  (chk_err)
  );

  if (REGISTERED) begin : g_reg
    logic valid_q;
    logic par_q;
    logic err_q;
    logic take;

    assign in_ready = !valid_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        par_q   <= 1'b0;
        err_q   <= 1'b0;
      end else if (take) begin
        valid_q <= 1'b1;
        par_q   <= gen_par;
        err_q   <= chk_err;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end

    assign out_valid = valid_q;
    assign out_par   = par_q;
    assign out_err   = err_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_par   = gen_par;
    assign out_err   = chk_err;
  end

endmodule

// File: rtl/parity_codec_props.sv
module parity_codec_props #(
  parameter int MSG_W      = 7,
  parameter bit REGISTERED = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             odd_sel,
  input logic             in_valid,
  input logic             in_ready,
  input logic [MSG_W-1:0] in_data,
  input logic             in_par,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_par,
  input logic             out_err
);

  if (REGISTERED) begin : g_reg_props
    AST_ACCEPT_NEXT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid); // R7
    AST_GEN_FROM_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_par == ((^$past(in_data)) ^ $past(odd_sel)))); // R1
    AST_CHK_FROM_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_err == ((^{$past(in_par), $past(in_data)}) ^ $past(odd_sel)))); // R3
    AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R8
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_par) && $stable(out_err))); // R8
  end else begin : g_comb_props
    AST_MATCHED_PAR_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (in_par == out_par)) |-> !out_err); // R3
    AST_MISMATCH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (in_par != out_par)) |-> out_err); // R4
  end

endmodule

bind parity_codec parity_codec_props #(
  .MSG_W      (MSG_W),
  .REGISTERED (REGISTERED)
) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .odd_sel   (odd_sel),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_par    (in_par),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_par   (out_par),
  .out_err   (out_err)
);

// File: tb/test_parity_codec.sv
module test_parity_codec;

  localparam int CLK_PERIOD = 10;
  localparam int WA = 7;
  localparam int WB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          r_odd, r_in_valid, r_in_ready, r_in_par, r_out_valid, r_out_ready, r_out_par, r_out_err;
  logic [WA-1:0] r_in_data;
  logic          c_odd, c_in_valid, c_in_ready, c_in_par, c_out_valid, c_out_ready, c_out_par, c_out_err;
  logic [WB-1:0] c_in_data;

  parity_codec #(.MSG_W(WA), .REGISTERED(1'b1)) i_parity_codec (
    .clk(clk), .rst_n(rst_n), .odd_sel(r_odd),
    .in_valid(r_in_valid), .in_ready(r_in_ready), .in_data(r_in_data), .in_par(r_in_par),
    .out_valid(r_out_valid), .out_ready(r_out_ready), .out_par(r_out_par), .out_err(r_out_err)
  );

  parity_codec #(.MSG_W(WB), .REGISTERED(1'b0)) i_parity_codec_w8 (
    .clk(clk), .rst_n(rst_n), .odd_sel(c_odd),
    .in_valid(c_in_valid), .in_ready(c_in_ready), .in_data(c_in_data), .in_par(c_in_par),
    .out_valid(c_out_valid), .out_ready(c_out_ready), .out_par(c_out_par), .out_err(c_out_err)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic ref_par(input logic [31:0] m, input int w, input logic odd);
    logic p = odd;
    for (int k = 0; k < w; k++) p ^= m[k];
    return p;
  endfunction

  function automatic logic ref_err(input logic [31:0] m, input logic par, input int w, input logic odd);
    return ref_par(m, w, 1'b0) ^ par ^ odd;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [WB-1:0] m8;
    logic          p8;
    logic          o8;
    r_odd = 0; r_in_valid = 0; r_in_data = '0; r_in_par = 0; r_out_ready = 1;
    c_odd = 0; c_in_valid = 0; c_in_data = '0; c_in_par = 0; c_out_ready = 0;
    void'($urandom(32'h5EED_0C0D));

    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", r_out_valid, 1'b0);
    check("R9 in_ready in reset", r_in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // Registered sweep, streaming one word per cycle
    for (int odd = 0; odd < 2; odd++) begin
      for (int m = 0; m < 128; m++) begin
        logic par_in;
        par_in     = 1'($urandom % 2);
        r_odd      = 1'(odd);
        r_in_data  = WA'(m);
        r_in_par   = par_in;
        r_in_valid = 1'b1;
        @(negedge clk);
        check("R7 out_valid one cycle after accept", r_out_valid, 1'b1);
        if (odd == 0) check("R1 even generated parity", r_out_par, ref_par(m, WA, 1'b0));
        else          check("R2 odd generated parity", r_out_par, ref_par(m, WA, 1'b1));
        check("R3 registered error flag", r_out_err, ref_err(m, par_in, WA, 1'(odd)));
      end
    end
    r_in_valid = 1'b0;
    @(negedge clk);
    check("R7 out_valid drops when idle", r_out_valid, 1'b0);

    // Back-pressure: A = msg 0, even, par 0 -> par 0 err 0; B = msg 1 -> par 1 err 1
    r_odd = 1'b0; r_out_ready = 1'b0;
    r_in_data = WA'(0); r_in_par = 1'b0; r_in_valid = 1'b1;
    @(negedge clk);
    check("R8 in_ready low while stalled", r_in_ready, 1'b0);
    r_in_data = WA'(1);
    @(negedge clk);
    check("R8 valid held", r_out_valid, 1'b1);
    check("R8 par held", r_out_par, 1'b0);
    check("R8 err held", r_out_err, 1'b0);
    r_out_ready = 1'b1;
    @(negedge clk);
    r_in_valid = 1'b0;
    check("R7 second word after release par", r_out_par, 1'b1);
    check("R7 second word after release err", r_out_err, 1'b1);

    // Unregistered pass-through
    @(negedge clk);
    c_in_valid = 1'b1; c_out_ready = 1'b0;
    #1;
    check("R10 out_valid follows in_valid", c_out_valid, 1'b1);
    check("R10 in_ready follows out_ready", c_in_ready, 1'b0);
    c_in_valid = 1'b0; c_out_ready = 1'b1;
    #1;
    check("R10 out_valid follows in_valid low", c_out_valid, 1'b0);
    check("R10 in_ready follows out_ready high", c_in_ready, 1'b1);
    c_in_valid = 1'b1;

    // Nine-bit word sweep with flips
    for (int odd = 0; odd < 2; odd++) begin
      for (int m = 0; m < 256; m++) begin
        int a;
        int b;
        @(negedge clk);
        m8 = WB'(m); o8 = 1'(odd);
        p8 = ref_par(m, WB, o8);
        c_odd = o8; c_in_data = m8; c_in_par = p8;
        #1;
        check("R6 nine-bit generated parity", c_out_par, p8);
        check("R3 clean word passes", c_out_err, 1'b0);
        for (int k = 0; k <= WB; k++) begin
          if (k < WB) begin c_in_data = m8 ^ (WB'(1) << k); c_in_par = p8; end
          else        begin c_in_data = m8;                 c_in_par = ~p8; end
          #1;
          check("R4 single flip detected", c_out_err, 1'b1);
        end
        a = int'($urandom % (WB + 1));
        b = (a + 1 + int'($urandom % WB)) % (WB + 1);
        c_in_data = m8; c_in_par = p8;
        if (a < WB) c_in_data[a] = ~c_in_data[a]; else c_in_par = ~c_in_par;
        if (b < WB) c_in_data[b] = ~c_in_data[b]; else c_in_par = ~c_in_par;
        #1;
        check("R5 double flip undetected", c_out_err, 1'b0);
      end
    end

    // Random words
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      m8 = WB'($urandom); p8 = 1'($urandom); o8 = 1'($urandom);
      c_odd = o8; c_in_data = m8; c_in_par = p8;
      #1;
      check("R3 random word error flag", c_out_err, ref_err(32'(m8), p8, WB, o8));
      check("R6 random nine-bit parity", c_out_par, ref_par(32'(m8), WB, o8));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule